// File: doc/BRIEF.md
# Double-Precision Issue Throttle

This block is the issue gate of an in-order SIMD core that has two floating-point datapaths: a four-lane single-precision FMA pipe that accepts one instruction every cycle, and a half-pumped double-precision FMA pipe whose two lanes run one after the other. Instructions arrive one at a time over a valid/ready handshake, each tagged with a kind (single precision, double precision or other) and an ID. Each cycle the block decides whether the head instruction may issue, and it holds back double-precision work so that the slow pipe is never overrun.

Two throttle policies exist. In the baseline policy a double-precision issue freezes all issue for a fixed number of cycles. In the enhanced policy, which assumes a longer forwarding network, only double-precision issues are spaced, by a minimum distance of two cycles, while other work flows freely. The requested policy is taken up only while no double-precision instruction is in flight. Results carry only a tag. Each one appears on a result port after the latency of its datapath. Three counters record single-precision issues, double-precision issues and cycles in which the head instruction was held.

Top module: `dp_issue_throttle`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the three counters read zero, both result-valid outputs are low and the active policy `mode_now` is baseline (0).
- R2: A single-precision instruction (in_kind 2'b01) accepted in cycle c shows its tag on sp_res_tag with sp_res_valid high in cycle c+6, for exactly that one cycle.
- R3: A double-precision instruction (in_kind 2'b10) accepted in cycle c shows its tag on dp_res_tag with dp_res_valid high in cycle c+13 (9 pipeline plus 4 overhead cycles), for exactly that one cycle.
- R4: In baseline policy (mode_now 0), after a double-precision instruction is accepted in cycle c, in_ready is low in cycles c+1 through c+6 whatever the kind presented, and the head is accepted no earlier than c+7.
- R5: In enhanced policy (mode_now 1), a double-precision instruction presented in the cycle right after a double-precision acceptance is held with in_ready low; one presented two cycles after an acceptance may issue.
- R6: In enhanced policy, in_ready is high whenever the presented kind is not double precision.
- R7: mode_now takes the value of mode_req only at an edge where no double-precision instruction was accepted in that cycle and none is still in the double-precision pipe; a request made while one is in flight takes effect after the pipe drains.
- R8: cnt_sp and cnt_dp rise by one after each cycle that accepts a single- or double-precision instruction respectively, and cnt_stall rises by one after each cycle with in_valid high and in_ready low.
- R9: An instruction of kind other (2'b00, and 2'b11 treated alike) issues when ready, counts in neither issue counter and produces no result on either result port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | Requested policy: 0 baseline, 1 enhanced |
| in_valid | input | 1 | Head instruction present |
| in_kind | input | 2 | Kind: 00 other, 01 single precision, 10 double precision, 11 other |
| in_tag | input | TAG_W | ID tag of the head instruction |
| in_ready | output | 1 | Head instruction may issue this cycle |
| mode_now | output | 1 | Policy currently in force |
| sp_res_valid | output | 1 | Single-precision result token present |
| sp_res_tag | output | TAG_W | Tag of the single-precision result |
| dp_res_valid | output | 1 | Double-precision result token present |
| dp_res_tag | output | TAG_W | Tag of the double-precision result |
| cnt_sp | output | CNT_W | Single-precision issues since reset |
| cnt_dp | output | CNT_W | Double-precision issues since reset |
| cnt_stall | output | CNT_W | Cycles with the head held since reset |

## Verification
The bound checker watches, on every cycle, the baseline freeze window after a double-precision issue, the one-cycle spacing of double-precision issues in enhanced policy, the free flow of other kinds in that policy, the rule that the policy changes only with an empty double-precision pipe, the counter increments and the reset values. That a result arrives with the right tag at exactly six or thirteen cycles, and that a policy request made mid-flight is deferred by the exact drain time, is shown by the bench's reference model, which is compared on every clock through sequences that mix kinds, hold double-precision instructions and switch policy while work is in flight.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_SP    = 2'b01,
        KIND_DP    = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_e;

    localparam logic MODE_BASE = 1'b0;
    localparam logic MODE_ENH  = 1'b1;

endpackage

// File: rtl/dpt_lat_pipe.sv
// Fixed-latency token pipe: a token entering in cycle c leaves in cycle c+LAT.
module dpt_lat_pipe #(
    parameter int LAT = 6,
    parameter int TW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [TW-1:0] in_tag,
    output logic          out_v,
    output logic [TW-1:0] out_tag,
    output logic          busy
);

    typedef struct packed {
        logic [LAT-1:0]         vld;
        logic [LAT-1:0][TW-1:0] tag;
    } pipe_t;

    pipe_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[LAT-2:0], in_v};
        st_d.tag = {st_q.tag[LAT-2:0], in_tag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_v   = st_q.vld[LAT-1];
    assign out_tag = st_q.tag[LAT-1];
    assign busy    = |st_q.vld;

endmodule

// File: rtl/dpt_issue_ctl.sv
// Issue decision, stall and spacing counters, and policy latch.
module dpt_issue_ctl
    import dpt_pkg::*;
#(
    parameter int DP_STALL = 6,
    parameter int DP_GAP   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req,
    input  logic       dp_busy,
    input  logic       in_valid,
    input  logic [1:0] in_kind,
    output logic       in_ready,
    output logic       sp_fire,
    output logic       dp_fire,
    output logic       held,
    output logic       mode_now
);

    localparam int SW = $clog2(DP_STALL + 1);
    localparam int GW = (DP_GAP > 1) ? $clog2(DP_GAP) : 1;
    localparam logic [SW-1:0] STALL_LOAD = SW'(DP_STALL);
    localparam logic [GW-1:0] GAP_LOAD   = GW'(DP_GAP - 1);

    typedef struct packed {
        logic [SW-1:0] stall;
        logic [GW-1:0] gap;
        logic          mode;
    } ctl_t;

    ctl_t st_d, st_q;

    logic is_dp, is_sp, blocked, fire;

    always_comb begin
        is_dp   = (in_kind == KIND_DP);
        is_sp   = (in_kind == KIND_SP);
        blocked = (st_q.stall != '0) ||
                  ((st_q.mode == MODE_ENH) && is_dp && (st_q.gap != '0));
        fire    = in_valid && !blocked;

        st_d = st_q;

        if (fire && is_dp && (st_q.mode == MODE_BASE)) begin
            st_d.stall = STALL_LOAD;
        end else if (st_q.stall != '0) begin
            st_d.stall = st_q.stall - 1'b1;
        end

        if (fire && is_dp && (st_q.mode == MODE_ENH)) begin
            st_d.gap = GAP_LOAD;
        end else if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end

        if (!dp_busy && !(fire && is_dp)) begin
            st_d.mode = mode_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = !blocked;
    assign sp_fire  = fire && is_sp;
    assign dp_fire  = fire && is_dp;
    assign held     = in_valid && blocked;
    assign mode_now = st_q.mode;

endmodule

// File: rtl/dpt_perf_cnt.sv
// Issue and hold counters.
module dpt_perf_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_sp,
    input  logic          inc_dp,
    input  logic          inc_hold,
    output logic [CW-1:0] cnt_sp,
    output logic [CW-1:0] cnt_dp,
    output logic [CW-1:0] cnt_hold
);

    typedef struct packed {
        logic [CW-1:0] sp;
        logic [CW-1:0] dp;
        logic [CW-1:0] hold;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inc_sp)   st_d.sp   = st_q.sp + 1'b1;
        if (inc_dp)   st_d.dp   = st_q.dp + 1'b1;
        if (inc_hold) st_d.hold = st_q.hold + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_sp   = st_q.sp;
    assign cnt_dp   = st_q.dp;
    assign cnt_hold = st_q.hold;

endmodule

// File: rtl/dp_issue_throttle.sv
module dp_issue_throttle #(
    parameter int TAG_W    = 8,
    parameter int CNT_W    = 16,
    parameter int SP_LAT   = 6,
    parameter int DP_PIPE  = 9,
    parameter int DP_OVH   = 4,
    parameter int DP_STALL = 6,
    parameter int DP_GAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_req,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [TAG_W-1:0] in_tag,
    output logic             in_ready,
    output logic             mode_now,
    output logic             sp_res_valid,
    output logic [TAG_W-1:0] sp_res_tag,
    output logic             dp_res_valid,
    output logic [TAG_W-1:0] dp_res_tag,
    output logic [CNT_W-1:0] cnt_sp,
    output logic [CNT_W-1:0] cnt_dp,
    output logic [CNT_W-1:0] cnt_stall
);

    localparam int DP_LAT = DP_PIPE + DP_OVH;

    logic sp_fire, dp_fire, held, dp_busy, sp_busy;

    dpt_issue_ctl #(
        .DP_STALL (DP_STALL),
        .DP_GAP   (DP_GAP)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .dp_busy  (dp_busy),
        .in_valid (in_valid),
        .in_kind  (in_kind),
        .in_ready (in_ready),
        .sp_fire  (sp_fire),
        .dp_fire  (dp_fire),
        .held     (held),
        .mode_now (mode_now)
    );

    dpt_lat_pipe #(
        .LAT (SP_LAT),
        .TW  (TAG_W)
    ) u_sp_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (sp_fire),
        .in_tag  (in_tag),
        .out_v   (sp_res_valid),
        .out_tag (sp_res_tag),
        .busy    (sp_busy)
    );

    dpt_lat_pipe #(
        .LAT (DP_LAT),
        .TW  (TAG_W)
    ) u_dp_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (dp_fire),
        .in_tag  (in_tag),
        .out_v   (dp_res_valid),
        .out_tag (dp_res_tag),
        .busy    (dp_busy)
    );

    dpt_perf_cnt #(
        .CW (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_sp   (sp_fire),
        .inc_dp   (dp_fire),
        .inc_hold (held),
        .cnt_sp   (cnt_sp),
        .cnt_dp   (cnt_dp),
        .cnt_hold (cnt_stall)
    );

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
    parameter int CNT_W    = 16,
    parameter int DP_STALL = 6,
    parameter int DP_LAT   = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_now,
    input logic             in_valid,
    input logic [1:0]       in_kind,
    input logic             in_ready,
    input logic             sp_res_valid,
    input logic             dp_res_valid,
    input logic [CNT_W-1:0] cnt_sp,
    input logic [CNT_W-1:0] cnt_dp,
    input logic [CNT_W-1:0] cnt_stall
);

    localparam int IFW = $clog2(DP_LAT + 2) + 1;
    localparam int SLW = $clog2(DP_STALL + 1);

    logic           acc, acc_sp, acc_dp;
    logic [IFW-1:0] sp_flight, dp_flight;
    logic [SLW-1:0] freeze_left;

    assign acc    = in_valid && in_ready;
    assign acc_sp = acc && (in_kind == 2'b01);
    assign acc_dp = acc && (in_kind == 2'b10);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_flight   <= '0;
            dp_flight   <= '0;
            freeze_left <= '0;
        end else begin
            sp_flight <= sp_flight + IFW'(acc_sp) - IFW'(sp_res_valid);
            dp_flight <= dp_flight + IFW'(acc_dp) - IFW'(dp_res_valid);
            if (acc_dp && !mode_now) begin
                freeze_left <= SLW'(DP_STALL);
            end else if (freeze_left != '0) begin
                freeze_left <= freeze_left - 1'b1;
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (cnt_sp == '0 && cnt_dp == '0 && cnt_stall == '0 &&
                    !sp_res_valid && !dp_res_valid && !mode_now));

    assert_sp_result_issued_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_res_valid |-> (sp_flight != '0));

    assert_dp_result_issued_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dp_res_valid |-> (dp_flight != '0));

    assert_base_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_left != '0) |-> !in_ready);

    assert_enh_dp_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now && acc_dp) |=> !((in_kind == 2'b10) && in_ready));

    assert_enh_nondp_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now && (in_kind != 2'b10)) |-> in_ready);

    assert_mode_change_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_now) |-> $past(dp_flight == '0 && !acc_dp));

    assert_cnt_sp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sp |=> (cnt_sp == CNT_W'($past(cnt_sp) + 1'b1)));

    assert_cnt_dp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_dp |=> (cnt_dp == CNT_W'($past(cnt_dp) + 1'b1)));

    assert_cnt_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (cnt_stall == CNT_W'($past(cnt_stall) + 1'b1)));

    assert_other_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !acc_sp && !acc_dp) |=> ($stable(cnt_sp) && $stable(cnt_dp)));

endmodule

bind dp_issue_throttle dpt_checker #(
    .CNT_W    (CNT_W),
    .DP_STALL (DP_STALL),
    .DP_LAT   (DP_PIPE + DP_OVH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_now     (mode_now),
    .in_valid     (in_valid),
    .in_kind      (in_kind),
    .in_ready     (in_ready),
    .sp_res_valid (sp_res_valid),
    .dp_res_valid (dp_res_valid),
    .cnt_sp       (cnt_sp),
    .cnt_dp       (cnt_dp),
    .cnt_stall    (cnt_stall)
);

// File: tb/dp_issue_throttle_tb.sv
`timescale 1ns/1ps
module dp_issue_throttle_tb;

    localparam int TW = 8;
    localparam int CW = 16;
    localparam int SP_L = 6;
    localparam int DP_L = 13;
    localparam int FREEZE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_req = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_kind = 2'b00;
    logic [TW-1:0] in_tag = '0;
    logic          in_ready, mode_now, sp_res_valid, dp_res_valid;
    logic [TW-1:0] sp_res_tag, dp_res_tag;
    logic [CW-1:0] cnt_sp, cnt_dp, cnt_stall;

    always #2.5 clk = ~clk;

    dp_issue_throttle u_dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
        .in_valid(in_valid), .in_kind(in_kind), .in_tag(in_tag),
        .in_ready(in_ready), .mode_now(mode_now),
        .sp_res_valid(sp_res_valid), .sp_res_tag(sp_res_tag),
        .dp_res_valid(dp_res_valid), .dp_res_tag(dp_res_tag),
        .cnt_sp(cnt_sp), .cnt_dp(cnt_dp), .cnt_stall(cnt_stall)
    );

    typedef struct { bit idle; logic [1:0] kind; logic [TW-1:0] tag; bit mreq; } stim_t;
    typedef struct { int due; logic [TW-1:0] tag; } res_t;

    stim_t stim[$];
    res_t  spq[$];
    res_t  dpq[$];

    int tests = 0;
    int fails = 0;
    int next_tag = 1;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input bit m);
        stim_t e;
        e.idle = 1'b0; e.kind = k; e.tag = TW'(next_tag); e.mreq = m;
        next_tag++;
        stim.push_back(e);
    endtask

    task automatic push_idle(input int n, input bit m);
        for (int i = 0; i < n; i++) begin
            stim_t e;
            e.idle = 1'b1; e.kind = 2'b00; e.tag = '0; e.mreq = m;
            stim.push_back(e);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int  cyc = 0;
        int  stall_rem = 0;
        int  gap_rem = 0;
        bit  m_mode = 1'b0;
        int  e_sp = 0, e_dp = 0, e_st = 0;
        bit  last_mreq = 1'b0;

        // baseline mixing, with other kinds and a held head
        push(2'b01, 0); push(2'b01, 0); push(2'b10, 0); push(2'b01, 0);
        push(2'b10, 0); push(2'b10, 0); push(2'b00, 0); push(2'b01, 0);
        push(2'b11, 0); push_idle(2, 0);
        // enhanced requested while a DP is in flight
        push(2'b10, 0); push(2'b10, 1); push(2'b01, 1); push(2'b10, 1);
        push(2'b10, 1); push(2'b01, 1); push(2'b10, 1); push(2'b00, 1);
        push(2'b10, 1); push(2'b01, 1); push(2'b01, 1); push_idle(16, 1);
        // enhanced with back-to-back DP
        push(2'b10, 1); push(2'b10, 1); push(2'b10, 1); push(2'b01, 1);
        push(2'b10, 1); push_idle(1, 1); push(2'b10, 1);
        // baseline requested mid-flight
        push(2'b10, 0); push(2'b01, 0); push(2'b10, 0); push(2'b01, 0);
        push_idle(4, 0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state straight after reset
        chk(cnt_sp == 0 && cnt_dp == 0 && cnt_stall == 0, "R1", "counters zero",
            int'(cnt_sp) + int'(cnt_dp) + int'(cnt_stall), 0);
        chk(!sp_res_valid && !dp_res_valid, "R1", "no result valid",
            int'(sp_res_valid) + int'(dp_res_valid), 0);
        chk(mode_now == 1'b0, "R1", "mode baseline", int'(mode_now), 0);
        chk(in_ready == 1'b1, "R1", "ready", int'(in_ready), 1);

        while (stim.size() > 0 || spq.size() > 0 || dpq.size() > 0) begin
            bit  is_dp, v, exp_ready, fire, exp_spv, exp_dpv;
            logic [TW-1:0] tg;
            if (cyc != 0) @(negedge clk);
            if (stim.size() > 0) begin
                in_valid = !stim[0].idle;
                in_kind  = stim[0].kind;
                in_tag   = stim[0].tag;
                mode_req = stim[0].mreq;
                last_mreq = stim[0].mreq;
            end else begin
                in_valid = 1'b0;
                in_kind  = 2'b00;
                in_tag   = '0;
                mode_req = last_mreq;
            end
            #1;
            v     = in_valid;
            is_dp = (in_kind == 2'b10);
            tg    = in_tag;
            exp_ready = !(stall_rem > 0 || (m_mode && is_dp && gap_rem > 0));
            if (stall_rem > 0)
                chk(in_ready == exp_ready, "R4", "ready in baseline freeze",
                    int'(in_ready), int'(exp_ready));
            else if (m_mode && is_dp)
                chk(in_ready == exp_ready, "R5", "ready for enhanced DP",
                    int'(in_ready), int'(exp_ready));
            else
                chk(in_ready == exp_ready, "R6", "ready for free head",
                    int'(in_ready), int'(exp_ready));
            chk(mode_now == m_mode, "R7", "mode_now", int'(mode_now), int'(m_mode));

            exp_spv = (spq.size() > 0 && spq[0].due == cyc);
            exp_dpv = (dpq.size() > 0 && dpq[0].due == cyc);
            chk(sp_res_valid == exp_spv, "R2", "sp_res_valid (R9 no extra)",
                int'(sp_res_valid), int'(exp_spv));
            if (exp_spv)
                chk(sp_res_tag == spq[0].tag, "R2", "sp_res_tag",
                    int'(sp_res_tag), int'(spq[0].tag));
            chk(dp_res_valid == exp_dpv, "R3", "dp_res_valid (R9 no extra)",
                int'(dp_res_valid), int'(exp_dpv));
            if (exp_dpv)
                chk(dp_res_tag == dpq[0].tag, "R3", "dp_res_tag",
                    int'(dp_res_tag), int'(dpq[0].tag));
            chk(int'(cnt_sp) == e_sp, "R8", "cnt_sp", int'(cnt_sp), e_sp);
            chk(int'(cnt_dp) == e_dp, "R8", "cnt_dp", int'(cnt_dp), e_dp);
            chk(int'(cnt_stall) == e_st, "R8", "cnt_stall", int'(cnt_stall), e_st);

            // advance the reference model to the next cycle
            fire = v && exp_ready;
            if (v && !exp_ready) e_st++;
            if (fire && in_kind == 2'b01) begin
                e_sp++;
                spq.push_back('{due: cyc + SP_L, tag: tg});
            end
            if (!(fire && is_dp) && dpq.size() == 0) m_mode = mode_req;
            if (fire && is_dp) begin
                e_dp++;
                if (!m_mode) stall_rem = FREEZE; else gap_rem = 1;
            end else begin
                if (stall_rem > 0) stall_rem--;
                if (gap_rem > 0) gap_rem--;
            end
            if (fire && is_dp) dpq.push_back('{due: cyc + DP_L, tag: tg});
            if (exp_spv) void'(spq.pop_front());
            if (exp_dpv) void'(dpq.pop_front());
            if (stim.size() > 0 && (stim[0].idle || fire)) void'(stim.pop_front());
            cyc++;
        end

        @(negedge clk);
        #1;
        chk(int'(cnt_sp) == e_sp, "R8", "final cnt_sp", int'(cnt_sp), e_sp);
        chk(int'(cnt_dp) == e_dp, "R8", "final cnt_dp", int'(cnt_dp), e_dp);
        chk(!sp_res_valid && !dp_res_valid, "R9", "no stray result",
            int'(sp_res_valid) + int'(dp_res_valid), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule